// File: doc/BRIEF.md
# I2C Shift and Buffer Register Unit

This block is the byte-level data path and software register view of a two-wire serial port. A separate protocol engine drives it with one strobe per bus bit. On each strobe the block shifts the sampled line level in and presents the next outgoing bit. When eight strobes have been taken, the assembled byte moves into a holding buffer that software reads through a small register port. The same event raises an interrupt flag.

Receive data is double-buffered, so the next byte can be assembled while software still holds the last one. Transmit data is not double-buffered: a software write to the data register loads the holding buffer and the shift register in the same clock edge. A single register offset reaches either the own-address register or the address mask register, and the mode field picks which one. In controller mode, the low seven bits of the own-address register are also presented as the baud-rate reload value.

Top module: `i2c_sbuf_unit`

## Requirements
- R1: On each cycle with `shift_en` high, the shift register moves one place toward its MSB and takes `sda_in` into bit 0. `sda_out` always shows the shift register's MSB. The eighth strobe since the last load or completion makes `byte_done` high for exactly the one cycle after that edge, and no earlier strobe does.
- R2: When a byte completes and the buffer is empty, the assembled byte (first bit shifted in = bit 7) is copied into the buffer, which reads at offset 0. The full bit (status offset 1, bit 0) is then set.
- R3: Every completed byte sets the interrupt flag, which is visible on `irq` and at flag offset 3, bit 0. It stays set until software writes a 0 to that bit. Writing a 1 to it has no effect.
- R4: A write to offset 0 loads the buffer and the shift register on the same edge and restarts the bit count at 0. `sda_out` shows bit 7 of the written value in the next cycle. A shift strobe in the same cycle as that write is ignored.
- R5: When a byte completes while the buffer is full and is not being read in that cycle, the buffer keeps its old byte and the overflow flag is set. The overflow flag is visible at status bit 1 and at flag offset 3, bit 1, and is cleared by writing 0 to flag bit 1.
- R6: A read strobe at offset 0 clears the full bit.
- R7: Status offset 1 bits [7:6] are read/write. Bits [5:0] are read-only: bit 0 full, bit 1 overflow, bits [4:2] bits shifted so far, bit 5 zero. Writes do not change bits [5:0].
- R8: Offset 2 is an 8-bit read/write control register whose bits [3:0] are the mode. Offset 4 reaches the mask register when the mode is 4'h9, and the own-address register otherwise. `own_addr` and `own_mask` always show the two registers.
- R9: `baud_reload` equals own-address bits [6:0] when the mode is 4'h8, and is 0 in every other mode.
- R10: After reset, every register reads 0 except the mask, which is 8'hFF. `irq`, `byte_done`, `sda_out` and `baud_reload` are 0. Unused offsets 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects only) |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current offset (combinational) |
| shift_en | input | 1 | One-bit shift strobe from the protocol engine |
| sda_in | input | 1 | Sampled data line level |
| sda_out | output | 1 | Next bit to drive (shift register MSB) |
| byte_done | output | 1 | One-cycle pulse after a byte completes |
| irq | output | 1 | Interrupt flag |
| own_addr | output | 8 | Own-address register |
| own_mask | output | 8 | Address mask register |
| baud_reload | output | 7 | Baud-rate reload value (controller mode only) |

## Verification
The hardest state to reach is an overflow. It needs two complete bytes without a read in between, so the bench shifts one pattern and then a second different one. It then checks that the first pattern survives in the buffer while both overflow views report the event. The transmit path is checked by writing a byte and counting seven strobes, stopping short of a completion, with `sda_out` compared against each expected bit. The bench then writes while also strobing to show that the strobe is dropped.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;
    localparam int MODE_W = 4;
    localparam int CNT_W  = $clog2(DATA_W);

    typedef enum logic [ADDR_W-1:0] {
        REG_DATA = 3'd0,
        REG_STAT = 3'd1,
        REG_CTRL = 3'd2,
        REG_FLAG = 3'd3,
        REG_ADDR = 3'd4
    } reg_e;

    localparam logic [MODE_W-1:0] MODE_CTRL_MASTER = 4'h8;
    localparam logic [MODE_W-1:0] MODE_MASK_ACCESS = 4'h9;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic             full;
        logic             ovf;
        logic             irq;
        logic [CNT_W-1:0] cnt;
    } rx_stat_t;

    function automatic logic hit_wr(bus_req_t r, reg_e a);
        return r.wr && (r.addr == a);
    endfunction

    function automatic logic hit_rd(bus_req_t r, reg_e a);
        return r.rd && (r.addr == a);
    endfunction
endpackage

// File: rtl/i2cb_shifter.sv
module i2cb_shifter #(
    parameter int DW = i2cb_pkg::DATA_W,
    localparam int CW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          shift_en,
    input  logic          sda_in,
    output logic [DW-1:0] sr,
    output logic [CW-1:0] cnt,
    output logic          complete,
    output logic [DW-1:0] new_byte
);
    logic take;

    assign take     = shift_en && !load;
    assign complete = take && (cnt == CW'(DW - 1));
    assign new_byte = {sr[DW-2:0], sda_in};

    always_ff @(posedge clk) begin
        if (rst) begin
            sr  <= '0;
            cnt <= '0;
        end else if (load) begin
            sr  <= load_data;
            cnt <= '0;
        end else if (take) begin
            sr  <= new_byte;
            cnt <= complete ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/i2cb_rxbuf.sv
module i2cb_rxbuf #(
    parameter int DW = i2cb_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          complete,
    input  logic [DW-1:0] new_byte,
    input  logic          rd_data,
    input  logic          wr_data,
    input  logic [DW-1:0] wdata,
    input  logic          flag_wr,
    input  logic [1:0]    flag_wdata,
    output logic [DW-1:0] buf_q,
    output logic          full_q,
    output logic          ovf_q,
    output logic          irq_q
);
    logic slot_busy;

    // a read in the same cycle frees the slot for the incoming byte
    assign slot_busy = full_q && !rd_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q  <= '0;
            full_q <= 1'b0;
            ovf_q  <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            if (wr_data)
                buf_q <= wdata;
            else if (complete && !slot_busy)
                buf_q <= new_byte;

            if (complete)
                full_q <= 1'b1;
            else if (rd_data)
                full_q <= 1'b0;

            if (complete && slot_busy)
                ovf_q <= 1'b1;
            else if (flag_wr && !flag_wdata[1])
                ovf_q <= 1'b0;

            if (complete)
                irq_q <= 1'b1;
            else if (flag_wr && !flag_wdata[0])
                irq_q <= 1'b0;
        end
    end
endmodule

// File: rtl/i2cb_regs.sv
module i2cb_regs
    import i2cb_pkg::*;
#(
    parameter int DW = DATA_W,
    localparam int CW = $clog2(DW),
    localparam int PADW = DW - 4 - CW
) (
    input  logic            clk,
    input  logic            rst,
    input  bus_req_t        req,
    input  rx_stat_t        rx,
    input  logic [DW-1:0]   buf_q,
    output logic [MODE_W-1:0] mode,
    output logic [DW-1:0]   own_addr,
    output logic [DW-1:0]   own_mask,
    output logic [DW-2:0]   baud_reload,
    output logic [DW-1:0]   rdata
);
    logic [DW-1:0] ctrl_q;
    logic [1:0]    stat_hi_q;
    logic [DW-1:0] addr_q;
    logic [DW-1:0] mask_q;
    logic          mask_sel;

    assign mode     = ctrl_q[MODE_W-1:0];
    assign mask_sel = (mode == MODE_MASK_ACCESS);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            stat_hi_q <= '0;
            addr_q    <= '0;
            mask_q    <= '1;
        end else begin
            if (hit_wr(req, REG_CTRL))
                ctrl_q <= req.wdata;
            if (hit_wr(req, REG_STAT))
                stat_hi_q <= req.wdata[DW-1:DW-2];
            if (hit_wr(req, REG_ADDR)) begin
                if (mask_sel)
                    mask_q <= req.wdata;
                else
                    addr_q <= req.wdata;
            end
        end
    end

    assign own_addr    = addr_q;
    assign own_mask    = mask_q;
    assign baud_reload = (mode == MODE_CTRL_MASTER) ? addr_q[DW-2:0] : '0;

    always_comb begin
        rdata = '0;
        case (req.addr)
            REG_DATA: rdata = buf_q;
            REG_STAT: rdata = {stat_hi_q, {PADW{1'b0}}, rx.cnt, rx.ovf, rx.full};
            REG_CTRL: rdata = ctrl_q;
            REG_FLAG: rdata = {{(DW-2){1'b0}}, rx.ovf, rx.irq};
            REG_ADDR: rdata = mask_sel ? mask_q : addr_q;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/i2c_sbuf_unit.sv
module i2c_sbuf_unit
    import i2cb_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    localparam int CW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          shift_en,
    input  logic          sda_in,
    output logic          sda_out,
    output logic          byte_done,
    output logic          irq,
    output logic [DW-1:0] own_addr,
    output logic [DW-1:0] own_mask,
    output logic [DW-2:0] baud_reload
);
    bus_req_t          req;
    rx_stat_t          rx;
    logic [DW-1:0]     sr;
    logic [CW-1:0]     cnt;
    logic              complete;
    logic [DW-1:0]     new_byte;
    logic [DW-1:0]     rx_buf;
    logic              rx_full;
    logic              rx_ovf;
    logic              rx_irq;
    logic [MODE_W-1:0] mode;
    logic              wr_data;
    logic              done_q;

    assign req     = '{wr: bus_wr, rd: bus_rd, addr: bus_addr, wdata: bus_wdata};
    assign wr_data = hit_wr(req, REG_DATA);

    i2cb_shifter #(.DW(DW)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (wr_data),
        .load_data (bus_wdata),
        .shift_en  (shift_en),
        .sda_in    (sda_in),
        .sr        (sr),
        .cnt       (cnt),
        .complete  (complete),
        .new_byte  (new_byte)
    );

    i2cb_rxbuf #(.DW(DW)) u_rxbuf (
        .clk        (clk),
        .rst        (rst),
        .complete   (complete),
        .new_byte   (new_byte),
        .rd_data    (hit_rd(req, REG_DATA)),
        .wr_data    (wr_data),
        .wdata      (bus_wdata),
        .flag_wr    (hit_wr(req, REG_FLAG)),
        .flag_wdata (bus_wdata[1:0]),
        .buf_q      (rx_buf),
        .full_q     (rx_full),
        .ovf_q      (rx_ovf),
        .irq_q      (rx_irq)
    );

    assign rx = '{full: rx_full, ovf: rx_ovf, irq: rx_irq, cnt: cnt};

    i2cb_regs #(.DW(DW)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .req         (req),
        .rx          (rx),
        .buf_q       (rx_buf),
        .mode        (mode),
        .own_addr    (own_addr),
        .own_mask    (own_mask),
        .baud_reload (baud_reload),
        .rdata       (bus_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) done_q <= 1'b0;
        else     done_q <= complete;
    end

    assign byte_done = done_q;
    assign sda_out   = sr[DW-1];
    assign irq       = rx_irq;
endmodule

// File: rtl/i2cb_chk.sv
module i2cb_chk #(
    parameter int DW = 8,
    parameter int AW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic [AW-1:0] bus_addr,
    input logic          shift_en,
    input logic          sda_out,
    input logic          byte_done,
    input logic          irq,
    input logic          full,
    input logic          ovf,
    input logic [DW-1:0] buf_q
);
    logic wr0;
    logic rd0;
    assign wr0 = bus_wr && (bus_addr == '0);
    assign rd0 = bus_rd && (bus_addr == '0);

    // R1
    done_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        byte_done |-> $past(shift_en));

    // R1
    sda_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(shift_en) && !$past(wr0)) |-> $stable(sda_out));

    // R2
    full_after_byte_chk: assert property (@(posedge clk) disable iff (rst)
        byte_done |-> full);

    // R3
    irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> byte_done);

    // R5
    ovf_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf) |-> byte_done);

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_done && $past(full) && !$past(rd0) && !$past(wr0)) |-> $stable(buf_q));
endmodule

bind i2c_sbuf_unit i2cb_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .shift_en  (shift_en),
    .sda_out   (sda_out),
    .byte_done (byte_done),
    .irq       (irq),
    .full      (rx_full),
    .ovf       (rx_ovf),
    .buf_q     (rx_buf)
);

// File: tb/tb_i2c_sbuf_unit.sv
`timescale 1ns/1ps
module tb_i2c_sbuf_unit;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       shift_en = 1'b0;
    logic       sda_in = 1'b0;
    logic       sda_out;
    logic       byte_done;
    logic       irq;
    logic [7:0] own_addr;
    logic [7:0] own_mask;
    logic [6:0] baud_reload;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    always #10 clk = ~clk;

    i2c_sbuf_unit dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .shift_en(shift_en), .sda_in(sda_in), .sda_out(sda_out),
        .byte_done(byte_done), .irq(irq), .own_addr(own_addr),
        .own_mask(own_mask), .baud_reload(baud_reload)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d, logic with_shift = 1'b0);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; shift_en = with_shift;
        @(negedge clk);
        bus_wr = 1'b0; shift_en = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d, input logic strobe = 1'b0);
        @(negedge clk);
        bus_addr = a; bus_rd = strobe;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic shift_bit(logic b);
        @(negedge clk);
        shift_en = 1'b1; sda_in = b;
        @(negedge clk);
        shift_en = 1'b0;
    endtask

    // shifts a byte MSB first; returns 1 if byte_done appeared only after the 8th bit
    task automatic shift_byte(logic [7:0] v, output bit ok);
        ok = 1;
        for (int i = 7; i >= 0; i--) begin
            shift_bit(v[i]);
            if (byte_done !== (i == 0)) ok = 0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        bit ok;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10: reset state
        check("R10 byte_done", {7'b0, byte_done}, 8'h00);
        check("R10 irq", {7'b0, irq}, 8'h00);
        check("R10 sda_out", {7'b0, sda_out}, 8'h00);
        check("R10 baud", {1'b0, baud_reload}, 8'h00);
        check("R10 own_addr", own_addr, 8'h00);
        check("R10 own_mask", own_mask, 8'hFF);
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            check($sformatf("R10 reg %0d", a), d, 8'h00);
        end

        // R1 R2 R3 R6: receive sweep
        for (int v = 0; v < 256; v += 5) begin
            shift_byte(8'(v), ok);
            check("R1 done timing", {7'b0, ok}, 8'h01);
            check("R3 irq set", {7'b0, irq}, 8'h01);
            rd(3'd1, d);
            check("R2 full set", d, 8'h01);
            rd(3'd0, d, 1'b1);
            check("R2 data", d, 8'(v));
            rd(3'd1, d);
            check("R6 full cleared", d, 8'h00);
            wr(3'd3, 8'hFF);
            check("R3 write one keeps", {7'b0, irq}, 8'h01);
            wr(3'd3, 8'h00);
            check("R3 write zero clears", {7'b0, irq}, 8'h00);
        end

        // R5: overflow keeps first byte
        shift_byte(8'hA5, ok);
        shift_byte(8'h3C, ok);
        check("R5 second done", {7'b0, ok}, 8'h01);
        rd(3'd1, d);
        check("R5 status ovf", d, 8'h03);
        rd(3'd3, d);
        check("R5 flag ovf", d, 8'h03);
        rd(3'd0, d, 1'b1);
        check("R5 buffer kept", d, 8'hA5);
        rd(3'd1, d);
        check("R5 ovf stays", d, 8'h02);
        wr(3'd3, 8'h01);
        rd(3'd3, d);
        check("R5 ovf cleared", d, 8'h01);
        wr(3'd3, 8'h00);
        rd(3'd3, d);
        check("R3 flags clear", d, 8'h00);

        // R4: transmit load and shift-out, stopping before completion
        for (int v = 1; v < 256; v += 23) begin
            logic [7:0] b;
            b = 8'(v);
            wr(3'd0, b);
            ok = (sda_out === b[7]);
            for (int i = 6; i >= 0; i--) begin
                shift_bit(1'b0);
                if (sda_out !== b[i]) ok = 0;
            end
            check("R4 shift out", {7'b0, ok}, 8'h01);
            rd(3'd1, d);
            check("R7 bit count 7", d, 8'h1C);
        end
        wr(3'd0, 8'h80, 1'b1);
        rd(3'd1, d);
        check("R4 strobe ignored on write", d, 8'h00);
        check("R4 msb after write", {7'b0, sda_out}, 8'h01);
        rd(3'd0, d);
        check("R4 buffer written", d, 8'h80);
        check("R4 no irq from load", {7'b0, irq}, 8'h00);

        // R7: status write mask
        wr(3'd1, 8'hFF);
        rd(3'd1, d);
        check("R7 upper bits rw", d, 8'hC0);
        wr(3'd1, 8'h40);
        rd(3'd1, d);
        check("R7 upper bits rw2", d, 8'h40);
        wr(3'd1, 8'h00);

        // R8: address / mask sharing
        wr(3'd4, 8'h5A);
        wr(3'd2, 8'h09);
        rd(3'd4, d);
        check("R8 mask read", d, 8'hFF);
        wr(3'd4, 8'h33);
        check("R8 own_mask", own_mask, 8'h33);
        check("R8 own_addr kept", own_addr, 8'h5A);
        wr(3'd2, 8'hF0);
        rd(3'd2, d);
        check("R8 ctrl rw", d, 8'hF0);
        rd(3'd4, d);
        check("R8 addr read", d, 8'h5A);
        check("R9 baud off", {1'b0, baud_reload}, 8'h00);

        // R9: baud reload sweep
        wr(3'd2, 8'h08);
        for (int v = 0; v < 256; v += 7) begin
            wr(3'd4, 8'(v));
            check("R9 baud master", {1'b0, baud_reload}, 8'(v) & 8'h7F);
            check("R8 own_addr", own_addr, 8'(v));
        end
        wr(3'd2, 8'h06);
        check("R9 baud slave", {1'b0, baud_reload}, 8'h00);
        wr(3'd2, 8'h09);
        check("R9 baud mask mode", {1'b0, baud_reload}, 8'h00);

        finish_run();
    end
endmodule